// File: doc/BRIEF.md
# Two-Channel DAC Input Latch Front End

This block is the digital front end of a two-channel 8-bit DAC. Each channel holds its sample in two stages: a write strobe loads an input latch, and a separate update clock moves that value into the DAC latch that drives the converter code. All strobes are level inputs sampled in one system clock domain. Only their rising edges act, and an edge is seen one system cycle after the level goes high.

A mode input picks between two pin maps. In dual mode, each channel has its own data bus, write strobe and update clock. In interleaved mode, port 1 carries the data for both channels, and the four strobe pins are reassigned:

- the port 1 write becomes the shared write;
- the port 1 clock becomes the shared update clock;
- the port 2 write becomes a channel select;
- the port 2 clock becomes a hold input that phase-aligns an internal divide-by-two of the update clock.

The block outputs the two DAC codes together with their complements. It also raises a one-cycle error flag when the select input is moved at an unsafe time.

Top module: `dac_latch_if`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both codes read 0, both complements read 255 and `sel_err_o` reads 0.
- R2: In dual mode (mode captured as 1), a rising edge on a channel's write loads its input latch without changing its code. The next rising edge on that channel's clock copies the input latch to the code output.
- R3: In dual mode, the two channels are independent. Strobes on one port never change the other channel's code.
- R4: When an update-clock rising edge and a write rising edge arrive in the same cycle, the code takes the input-latch value that was held before that write.
- R5: Each complement output equals 255 minus its channel code.
- R6: In interleaved mode (mode captured as 0), a write edge stores the port 1 data into channel 1 when the select (port 2 write) is 1, and into channel 2 when it is 0. Port 2 data is ignored.
- R7: In interleaved mode, update-clock edges (port 1 clock) have no effect while the hold input (port 2 clock) is high. The first edge after the hold input falls updates both codes together.
- R8: In interleaved mode, after that first update, both codes update only on every second rising edge of the update clock.
- R9: The mode input is captured on the first clock after reset is released. Later changes to it have no effect until the next reset.
- R10: In interleaved mode, `sel_err_o` pulses high for one cycle, one cycle after the select changes while the port 1 write or port 1 clock level is high. It stays low otherwise.
- R11: A strobe held high acts only once, on its rising edge. Data changes while the write stays high are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = dual, 0 = interleaved; captured after reset |
| p1_data_i | input | 8 | Port 1 data (shared bus when interleaved) |
| p1_wr_i | input | 1 | Port 1 write / shared write |
| p1_clk_i | input | 1 | Port 1 update clock / shared update clock |
| p2_data_i | input | 8 | Port 2 data (ignored when interleaved) |
| p2_wr_i | input | 1 | Port 2 write / channel select |
| p2_clk_i | input | 1 | Port 2 update clock / divider hold |
| ch1_code_o | output | 8 | Channel 1 DAC latch code |
| ch2_code_o | output | 8 | Channel 2 DAC latch code |
| ch1_comp_o | output | 8 | Channel 1 complementary code |
| ch2_comp_o | output | 8 | Channel 2 complementary code |
| sel_err_o | output | 1 | Select-changed-while-strobe-high flag |

## Verification
The hardest state to reach is the divide-by-two phase in interleaved mode. The stimulus first raises the hold input and writes both channels. It then pulses the update clock while the hold input is still high, to show that edge is ignored. After the hold input drops, it pulses the update clock three more times: the first edge updates both codes, the second is skipped and the third updates again. Along the way, the mode input is flipped after capture and port 2 data is set to a decoy value, so that a live mode input or a wrong data path would show up as a code mismatch.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic {
    MODE_IQ   = 1'b0,
    MODE_DUAL = 1'b1
  } dac_mode_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dac_rise_det.sv
module dac_rise_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R11
  held_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_o & $past(lvl_i)) == '0));
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          upd_i,
  output logic [DW-1:0] code_o
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] dac_q;

  // Non-blocking update: a same-cycle write is not seen by the DAC latch.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (wr_i)  in_q  <= data_i;
      if (upd_i) dac_q <= in_q;
    end
  end

  assign code_o = dac_q;

  // R2
  hold_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(code_o));
endmodule

// File: rtl/dac_iq_ctrl.sv
module dac_iq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_rise_i,
  input  logic wr_lvl_i,
  input  logic clk_rise_i,
  input  logic clk_lvl_i,
  input  logic sel_i,
  input  logic hold_i,
  output logic wr1_o,
  output logic wr2_o,
  output logic upd_o,
  output logic err_o
);
  logic phase_q;
  logic sel_q;
  logic err_q;

  assign wr1_o = en_i & wr_rise_i &  sel_i;
  assign wr2_o = en_i & wr_rise_i & ~sel_i;
  // phase 0 -> this edge updates, phase 1 -> this edge is skipped
  assign upd_o = en_i & clk_rise_i & ~hold_i & ~phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      sel_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sel_q <= sel_i;
      err_q <= en_i & (sel_i != sel_q) & (wr_lvl_i | clk_lvl_i);
      if (!en_i || hold_i)  phase_q <= 1'b0;
      else if (clk_rise_i)  phase_q <= ~phase_q;
    end
  end

  assign err_o = err_q;

  // R7
  no_upd_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !upd_o);
  // R8
  skip_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !hold_i) |=> (phase_q || !en_i));
endmodule

// File: rtl/dac_latch_if.sv
module dac_latch_if
  import dac_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [DW-1:0] p1_data_i,
  input  logic          p1_wr_i,
  input  logic          p1_clk_i,
  input  logic [DW-1:0] p2_data_i,
  input  logic          p2_wr_i,
  input  logic          p2_clk_i,
  output logic [DW-1:0] ch1_code_o,
  output logic [DW-1:0] ch2_code_o,
  output logic [DW-1:0] ch1_comp_o,
  output logic [DW-1:0] ch2_comp_o,
  output logic          sel_err_o
);
  localparam int unsigned NSTB = 2 * NUM_CH;

  logic      init_q;
  dac_mode_e mode_q;
  logic      dual, iq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      mode_q <= MODE_DUAL;
    end else if (!init_q) begin
      init_q <= 1'b1;
      mode_q <= dac_mode_e'(mode_i);
    end
  end

  assign dual = init_q & (mode_q == MODE_DUAL);
  assign iq   = init_q & (mode_q == MODE_IQ);

  // strobe order: {p2_clk, p2_wr, p1_clk, p1_wr}
  logic [NSTB-1:0] lvl, rise;
  assign lvl = {p2_clk_i, p2_wr_i, p1_clk_i, p1_wr_i};

  dac_rise_det #(.N(NSTB)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  logic iq_wr1, iq_wr2, iq_upd, iq_err;

  dac_iq_ctrl u_iq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (iq),
    .wr_rise_i  (rise[0]),
    .wr_lvl_i   (p1_wr_i),
    .clk_rise_i (rise[1]),
    .clk_lvl_i  (p1_clk_i),
    .sel_i      (p2_wr_i),
    .hold_i     (p2_clk_i),
    .wr1_o      (iq_wr1),
    .wr2_o      (iq_wr2),
    .upd_o      (iq_upd),
    .err_o      (iq_err)
  );

  logic [NUM_CH-1:0]   wr_en, upd_en;
  logic [DW-1:0]       ch_data [NUM_CH];
  logic [DW-1:0]       ch_code [NUM_CH];
  logic [DW-1:0]       dual_data [NUM_CH];
  logic [NUM_CH-1:0]   iq_wr;

  assign dual_data[0] = p1_data_i;
  assign dual_data[1] = p2_data_i;
  assign iq_wr        = {iq_wr2, iq_wr1};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_en[g]   = dual ? rise[2*g]   : iq_wr[g];
    assign upd_en[g]  = dual ? rise[2*g+1] : iq_upd;
    assign ch_data[g] = dual ? dual_data[g] : p1_data_i;

    dac_chan #(.DW(DW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en[g]),
      .data_i (ch_data[g]),
      .upd_i  (upd_en[g]),
      .code_o (ch_code[g])
    );
  end

  assign ch1_code_o = ch_code[0];
  assign ch2_code_o = ch_code[1];
  assign ch1_comp_o = ~ch_code[0];
  assign ch2_comp_o = ~ch_code[1];
  assign sel_err_o  = iq_err;

  // R9
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> $stable(mode_q));
  // R6
  iq_one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq |-> $onehot0(wr_en));
  // R10
  no_err_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dual) |-> !sel_err_o);
endmodule

// File: tb/dac_latch_if_bench.sv
module dac_latch_if_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic [7:0] d1 = '0, d2 = '0;
  logic       w1 = 0, c1 = 0, w2 = 0, c2 = 0;
  logic [7:0] q1, q2, k1, k2;
  logic       err;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dac_latch_if u_dac_latch_if (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .p1_data_i(d1), .p1_wr_i(w1), .p1_clk_i(c1),
    .p2_data_i(d2), .p2_wr_i(w2), .p2_clk_i(c2),
    .ch1_code_o(q1), .ch2_code_o(q2),
    .ch1_comp_o(k1), .ch2_comp_o(k2),
    .sel_err_o(err)
  );

  // {w1, c1, d1, w2, c2, d2, exp1, exp2}
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,1'b0,8'h3C, 1'b0,1'b0,8'h00, 8'h00,8'h00}, // R2 write, no update
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h00,8'h00},
    {1'b0,1'b1,8'h00, 1'b0,1'b0,8'h00, 8'h3C,8'h00}, // R2 update, R3
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h3C,8'h00},
    {1'b1,1'b0,8'h11, 1'b1,1'b0,8'hA5, 8'h3C,8'h00},
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h3C,8'h00},
    {1'b0,1'b0,8'h00, 1'b0,1'b1,8'h00, 8'h3C,8'hA5}, // R3
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h3C,8'hA5},
    {1'b1,1'b1,8'h77, 1'b0,1'b0,8'h00, 8'h11,8'hA5}, // R4 old value
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h11,8'hA5},
    {1'b0,1'b1,8'h00, 1'b0,1'b0,8'h00, 8'h77,8'hA5},
    {1'b1,1'b0,8'h22, 1'b0,1'b0,8'h00, 8'h77,8'hA5}, // R11
    {1'b1,1'b0,8'h99, 1'b0,1'b0,8'h00, 8'h77,8'hA5}, // R11 held
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h77,8'hA5},
    {1'b0,1'b1,8'h00, 1'b0,1'b0,8'h00, 8'h22,8'hA5}, // R11 first data
    {1'b0,1'b0,8'h00, 1'b1,1'b0,8'hFF, 8'h22,8'hA5},
    {1'b0,1'b0,8'h00, 1'b0,1'b1,8'h00, 8'h22,8'hFF},
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 8'h22,8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic codes(input string tag, input logic [7:0] e1, input logic [7:0] e2);
    chk(tag, q1, e1);
    chk(tag, q2, e2);
    chk({tag, " R5 comp1"}, k1, 8'd255 - e1);
    chk({tag, " R5 comp2"}, k2, 8'd255 - e2);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode = m;
    step(); step();
    codes("R1 in reset", 8'h00, 8'h00);
    chk("R1 err", {7'd0, err}, 8'd0);
    rst_n = 1'b1;
    step();
    step();
    codes("R1 after reset", 8'h00, 8'h00);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    step();
    do_reset(1'b1);

    for (int i = 0; i < NV; i++) begin
      {w1, c1, d1, w2, c2, d2} = VEC[i][35:16];
      step();
      codes($sformatf("R2/R3/R4/R11 vec %0d", i), VEC[i][15:8], VEC[i][7:0]);
      chk("R10 dual no err", {7'd0, err}, 8'd0);
    end
    {w1, c1, d1, w2, c2, d2} = '0;

    // Interleaved mode
    c2 = 1'b1;
    do_reset(1'b0);
    mode = 1'b1; // R9 change ignored
    d2 = 8'hEE;  // R6 decoy
    w2 = 1'b1; d1 = 8'h40; step();
    w1 = 1'b1; step(); w1 = 1'b0; step();
    w2 = 1'b0; d1 = 8'h80; step();
    w1 = 1'b1; step(); w1 = 1'b0; step();
    c1 = 1'b1; step();
    codes("R7 clk in hold", 8'h00, 8'h00);
    c1 = 1'b0; step();
    c2 = 1'b0; step();
    c1 = 1'b1; step();
    codes("R6 R7 R9 first update", 8'h40, 8'h80);
    c1 = 1'b0; step();
    w2 = 1'b1; d1 = 8'h41; step();
    w1 = 1'b1; step(); w1 = 1'b0; step();
    w2 = 1'b0; d1 = 8'h81; step();
    w1 = 1'b1; step(); w1 = 1'b0; step();
    c1 = 1'b1; step();
    codes("R8 skipped edge", 8'h40, 8'h80);
    c1 = 1'b0; step();
    c1 = 1'b1; step();
    codes("R8 second update", 8'h41, 8'h81);
    c1 = 1'b0; step();
    chk("R10 no err", {7'd0, err}, 8'd0);
    w1 = 1'b1; step();
    w2 = 1'b1; step();
    chk("R10 err set", {7'd0, err}, 8'd1);
    w1 = 1'b0; step();
    chk("R10 err pulse", {7'd0, err}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule